// File: doc/BRIEF.md
# Operand Interlock Unit

This block decides, every cycle, whether the instruction sitting in decode of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) may move on into execute. It compares the decode instruction's source register tags with the destination tags of the two older instructions still in execute and memory. It uses their instruction classes to tell when a result is not yet reachable through forwarding. Simple ALU results are forwarded and never hold decode. Multiply-accumulate and load results arrive late. A store writes no register, but in decode it needs room in the write buffer.

When the unit raises `stall_o`, fetch and decode keep their contents and execute receives an empty slot. The older stages keep moving, so every hazard clears by itself. `bubble_o` is a registered flag that marks the cycles in which execute holds such an inserted empty slot. The accumulate operand of a multiply-accumulate is read one cycle after its multiplier operands, so the unit treats it under a more relaxed rule.

Top module: `operand_interlock`

## Requirements
- R1: Class inputs are encoded ALU=0, MAC=1, LOAD=2, STORE=3. An ALU producer in execute or memory never causes a stall, even when its destination matches a decode source.
- R2: A MAC producer in execute whose destination matches a valid multiplier operand (operand A or B) of the decode instruction stalls decode.
- R3: When the decode instruction is a MAC that depends on a MAC in execute only through its accumulate operand, no stall is raised.
- R4: A load result matched by operand A or B stalls decode for two cycles when the load is the previous instruction, for one cycle when it is two instructions earlier, and not at all when it is three or more instructions earlier.
- R5: A MAC in decode whose accumulate operand matches a load stalls while the load is in execute but not while it is in memory, so a back-to-back pair costs one cycle.
- R6: A STORE producer in execute or memory never causes a stall, whatever tag is on its destination input.
- R7: A STORE in decode stalls exactly in the cycles where the write-buffer-full input is high. That input has no effect for any other decode class.
- R8: A stall is only raised while the decode valid is high. Sources with their valid low, producers with their stage valid low, and an accumulate tag on a non-MAC decode instruction never cause a stall.
- R9: If the instruction in execute writes the same register as the one in memory, the memory stage is shadowed and its match is ignored.
- R10: `bubble_o` is low in reset. Afterwards it is high in exactly the cycles that follow a cycle with `stall_o` high.
- R11: A MAC producer in the memory stage never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage holds an instruction |
| dec_cls_i | input | 2 | Decode instruction class |
| dec_opa_tag_i | input | TAG_W | Operand A register tag |
| dec_opa_vld_i | input | 1 | Operand A is read |
| dec_opb_tag_i | input | TAG_W | Operand B register tag |
| dec_opb_vld_i | input | 1 | Operand B is read |
| dec_acc_tag_i | input | TAG_W | Accumulate operand register tag |
| dec_acc_vld_i | input | 1 | Accumulate operand is read |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_cls_i | input | 2 | Execute instruction class |
| ex_dst_tag_i | input | TAG_W | Execute destination tag |
| mem_valid_i | input | 1 | Memory stage holds an instruction |
| mem_cls_i | input | 2 | Memory instruction class |
| mem_dst_tag_i | input | TAG_W | Memory destination tag |
| wbuf_full_i | input | 1 | Write buffer cannot take a store |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| bubble_o | output | 1 | Execute holds an inserted empty slot |

## Verification
The assertions assume that the stage inputs describe a real pipeline. An execute or memory entry is only meaningful with its valid high, and the classes follow the stated encoding. The bench enforces this by building the stage inputs from its own behavioural pipeline. That pipeline advances on its own predicted stall decision and feeds random tags only into slots whose valid is low. Directed programs cover each hazard distance and each operand kind. Random programs then mix all classes and a randomly toggling write-buffer-full input.

// File: rtl/oi_pkg.sv
package oi_pkg;
  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_MAC   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } op_cls_e;
endpackage

// File: rtl/oi_tag_match.sv
module oi_tag_match #(
  parameter int TAG_W = 4,
  parameter int N_SRC = 3
) (
  input  logic [TAG_W-1:0]            prod_tag_i,
  input  logic                        prod_wr_i,
  input  logic [N_SRC-1:0][TAG_W-1:0] src_tag_i,
  input  logic [N_SRC-1:0]            src_vld_i,
  output logic [N_SRC-1:0]            hit_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign hit_o[s] = prod_wr_i && src_vld_i[s] && (src_tag_i[s] == prod_tag_i);
  end
endmodule

// File: rtl/oi_stage_rule.sv
module oi_stage_rule
  import oi_pkg::*;
#(
  parameter int DIST = 1  // producer distance from decode, 1 = execute
) (
  input  logic [1:0] cls_i,
  input  logic       norm_hit_i,
  input  logic       acc_hit_i,
  output logic       haz_o
);
  op_cls_e cls;
  assign cls = op_cls_e'(cls_i);

  if (DIST == 1) begin : g_near
    always_comb begin
      unique case (cls)
        CLS_MAC:  haz_o = norm_hit_i;
        CLS_LOAD: haz_o = norm_hit_i || acc_hit_i;
        default:  haz_o = 1'b0;
      endcase
    end
  end else begin : g_far
    // accumulate is read a cycle late, a load two back is ready for it
    logic unused_acc;
    assign unused_acc = acc_hit_i;
    assign haz_o = (cls == CLS_LOAD) && norm_hit_i;
  end
endmodule

// File: rtl/operand_interlock.sv
module operand_interlock
  import oi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [1:0]       dec_cls_i,
  input  logic [TAG_W-1:0] dec_opa_tag_i,
  input  logic             dec_opa_vld_i,
  input  logic [TAG_W-1:0] dec_opb_tag_i,
  input  logic             dec_opb_vld_i,
  input  logic [TAG_W-1:0] dec_acc_tag_i,
  input  logic             dec_acc_vld_i,
  input  logic             ex_valid_i,
  input  logic [1:0]       ex_cls_i,
  input  logic [TAG_W-1:0] ex_dst_tag_i,
  input  logic             mem_valid_i,
  input  logic [1:0]       mem_cls_i,
  input  logic [TAG_W-1:0] mem_dst_tag_i,
  input  logic             wbuf_full_i,
  output logic             stall_o,
  output logic             bubble_o
);
  localparam int N_SRC   = 3;
  localparam int SRC_ACC = N_SRC - 1;
  localparam int N_STG   = 2;

  op_cls_e dec_cls;
  assign dec_cls = op_cls_e'(dec_cls_i);

  logic [N_SRC-1:0][TAG_W-1:0] src_tag;
  logic [N_SRC-1:0]            src_vld;
  assign src_tag = {dec_acc_tag_i, dec_opb_tag_i, dec_opa_tag_i};
  assign src_vld = {dec_acc_vld_i && (dec_cls == CLS_MAC), dec_opb_vld_i, dec_opa_vld_i};

  logic ex_wr, mem_wr, mem_shadow;
  assign ex_wr      = ex_valid_i && (ex_cls_i != CLS_STORE);
  assign mem_shadow = ex_wr && (ex_dst_tag_i == mem_dst_tag_i);
  assign mem_wr     = mem_valid_i && (mem_cls_i != CLS_STORE) && !mem_shadow;

  logic [N_STG-1:0][TAG_W-1:0] prod_tag;
  logic [N_STG-1:0][1:0]       prod_cls;
  logic [N_STG-1:0]            prod_wr;
  logic [N_STG-1:0]            stg_haz;
  assign prod_tag = {mem_dst_tag_i, ex_dst_tag_i};
  assign prod_cls = {mem_cls_i, ex_cls_i};
  assign prod_wr  = {mem_wr, ex_wr};

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    logic [N_SRC-1:0] hit;
    oi_tag_match #(.TAG_W(TAG_W), .N_SRC(N_SRC)) u_match (
      .prod_tag_i(prod_tag[g]),
      .prod_wr_i (prod_wr[g]),
      .src_tag_i (src_tag),
      .src_vld_i (src_vld),
      .hit_o     (hit)
    );
    oi_stage_rule #(.DIST(g + 1)) u_rule (
      .cls_i     (prod_cls[g]),
      .norm_hit_i(|hit[SRC_ACC-1:0]),
      .acc_hit_i (hit[SRC_ACC]),
      .haz_o     (stg_haz[g])
    );
  end

  logic store_block;
  assign store_block = (dec_cls == CLS_STORE) && wbuf_full_i;
  assign stall_o     = dec_valid_i && ((|stg_haz) || store_block);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bubble_o <= 1'b0;
    else         bubble_o <= stall_o;
  end

  // R8
  stall_needs_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> dec_valid_i);

  // R7
  store_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_cls_i == CLS_STORE && wbuf_full_i) |-> stall_o);

  // R1 R11
  fast_prod_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_cls_i != CLS_STORE &&
     (!ex_valid_i || ex_cls_i == CLS_ALU || ex_cls_i == CLS_STORE) &&
     (!mem_valid_i || mem_cls_i != CLS_LOAD)) |-> !stall_o);

  // R3
  acc_only_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_cls_i == CLS_MAC && ex_valid_i && ex_cls_i == CLS_MAC &&
     !mem_valid_i && dec_acc_tag_i == ex_dst_tag_i &&
     !(dec_opa_vld_i && dec_opa_tag_i == ex_dst_tag_i) &&
     !(dec_opb_vld_i && dec_opb_tag_i == ex_dst_tag_i)) |-> !stall_o);

  // R6
  store_prod_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_cls_i != CLS_STORE && ex_cls_i == CLS_STORE && mem_cls_i == CLS_STORE) |-> !stall_o);
endmodule

// File: tb/operand_interlock_tb_top.sv
module operand_interlock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;
  localparam int N_REG = 1 << TAG_W;

  typedef struct {
    int cls; int dst;
    int a; bit av; int b; bit bv; int acc; bit accv;
  } ins_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic dec_valid, dec_opa_vld, dec_opb_vld, dec_acc_vld, ex_valid, mem_valid, wbuf_full;
  logic [1:0] dec_cls, ex_cls, mem_cls;
  logic [TAG_W-1:0] dec_opa_tag, dec_opb_tag, dec_acc_tag, ex_dst_tag, mem_dst_tag;
  logic stall_o, bubble_o;

  int errors = 0, checks = 0;
  bit exp_bub = 1'b0;
  bit done = 1'b0;
  ins_t prog[$];
  int rdy_n[N_REG];
  int rdy_a[N_REG];

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_interlock #(.TAG_W(TAG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .dec_valid_i(dec_valid), .dec_cls_i(dec_cls),
    .dec_opa_tag_i(dec_opa_tag), .dec_opa_vld_i(dec_opa_vld),
    .dec_opb_tag_i(dec_opb_tag), .dec_opb_vld_i(dec_opb_vld),
    .dec_acc_tag_i(dec_acc_tag), .dec_acc_vld_i(dec_acc_vld),
    .ex_valid_i(ex_valid), .ex_cls_i(ex_cls), .ex_dst_tag_i(ex_dst_tag),
    .mem_valid_i(mem_valid), .mem_cls_i(mem_cls), .mem_dst_tag_i(mem_dst_tag),
    .wbuf_full_i(wbuf_full), .stall_o(stall_o), .bubble_o(bubble_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic ins_t mk(int cls, int dst, int a, bit av, int b, bit bv, int acc, bit accv);
    ins_t i;
    i.cls = cls; i.dst = dst; i.a = a; i.av = av; i.b = b; i.bv = bv; i.acc = acc; i.accv = accv;
    return i;
  endfunction

  // cls: 0 ALU, 1 MAC, 2 LOAD, 3 STORE
  task automatic add(int cls, int dst, int a = 0, bit av = 0, int b = 0, bit bv = 0,
                     int acc = 0, bit accv = 0);
    prog.push_back(mk(cls, dst, a, av, b, bv, acc, accv));
  endtask

  task automatic run(string req, int exp_total, int wb_full_n, bit wb_rand);
    int dec_s = (prog.size() > 0) ? 0 : -1;
    int ex_s = -1, mem_s = -1, nxt = 1, cyc = 0, n_dut = 0;
    bit es, full;
    for (int r = 0; r < N_REG; r++) begin rdy_n[r] = 0; rdy_a[r] = 0; end
    while (dec_s >= 0 || ex_s >= 0 || mem_s >= 0) begin
      @(negedge clk);
      full = wb_rand ? 1'($urandom_range(0, 1)) : (cyc < wb_full_n);
      wbuf_full = full;
      dec_valid = dec_s >= 0;
      if (dec_s >= 0) begin
        dec_cls = 2'(prog[dec_s].cls);
        dec_opa_tag = TAG_W'(prog[dec_s].a);   dec_opa_vld = prog[dec_s].av;
        dec_opb_tag = TAG_W'(prog[dec_s].b);   dec_opb_vld = prog[dec_s].bv;
        dec_acc_tag = TAG_W'(prog[dec_s].acc); dec_acc_vld = prog[dec_s].accv;
      end else begin
        dec_cls = 2'($urandom_range(0, 3));
        dec_opa_tag = TAG_W'($urandom); dec_opa_vld = 1'b1;
        dec_opb_tag = TAG_W'($urandom); dec_opb_vld = 1'b1;
        dec_acc_tag = TAG_W'($urandom); dec_acc_vld = 1'b1;
      end
      ex_valid = ex_s >= 0;
      ex_cls = (ex_s >= 0) ? 2'(prog[ex_s].cls) : 2'($urandom_range(0, 3));
      ex_dst_tag = (ex_s >= 0) ? TAG_W'(prog[ex_s].dst) : TAG_W'($urandom);
      mem_valid = mem_s >= 0;
      mem_cls = (mem_s >= 0) ? 2'(prog[mem_s].cls) : 2'($urandom_range(0, 3));
      mem_dst_tag = (mem_s >= 0) ? TAG_W'(prog[mem_s].dst) : TAG_W'($urandom);
      es = 1'b0;
      if (dec_s >= 0) begin
        if (prog[dec_s].cls == 3 && full) es = 1'b1;
        if (prog[dec_s].av && cyc < rdy_n[prog[dec_s].a]) es = 1'b1;
        if (prog[dec_s].bv && cyc < rdy_n[prog[dec_s].b]) es = 1'b1;
        if (prog[dec_s].cls == 1 && prog[dec_s].accv && cyc < rdy_a[prog[dec_s].acc]) es = 1'b1;
      end
      #1;
      check(req, "stall_o", int'(stall_o), int'(es));
      check("R10", "bubble_o", int'(bubble_o), int'(exp_bub));
      n_dut += int'(stall_o);
      @(posedge clk);
      exp_bub = es;
      mem_s = ex_s;
      if (!es && dec_s >= 0) begin
        case (prog[dec_s].cls)
          0: begin rdy_n[prog[dec_s].dst] = cyc + 1; rdy_a[prog[dec_s].dst] = cyc + 1; end
          1: begin rdy_n[prog[dec_s].dst] = cyc + 2; rdy_a[prog[dec_s].dst] = cyc + 1; end
          2: begin rdy_n[prog[dec_s].dst] = cyc + 3; rdy_a[prog[dec_s].dst] = cyc + 2; end
          default: ;
        endcase
        ex_s = dec_s;
        dec_s = (nxt < prog.size()) ? nxt : -1;
        nxt++;
      end else begin
        ex_s = -1;
      end
      cyc++;
    end
    if (exp_total >= 0) check(req, "stall cycles", n_dut, exp_total);
    prog.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    dec_valid = 0; dec_cls = 0; dec_opa_tag = 0; dec_opa_vld = 0; dec_opb_tag = 0;
    dec_opb_vld = 0; dec_acc_tag = 0; dec_acc_vld = 0; ex_valid = 0; ex_cls = 0;
    ex_dst_tag = 0; mem_valid = 0; mem_cls = 0; mem_dst_tag = 0; wbuf_full = 0;
    repeat (3) @(negedge clk);
    check("R10", "bubble_o in reset", int'(bubble_o), 0);
    check("R8", "stall_o with decode empty", int'(stall_o), 0);
    rst_ni = 1'b1;

    // R1 ALU result used next
    add(0, 1); add(0, 2, 1, 1); add(0, 3, 2, 1, 1, 1);
    run("R1", 0, 0, 0);
    // R2 MAC result as multiplier operand
    add(1, 2, 5, 1, 6, 1); add(0, 4, 0, 0, 2, 1);
    run("R2", 1, 0, 0);
    // R3 MAC chain through accumulate only
    add(1, 3, 5, 1, 6, 1, 9, 1); add(1, 3, 5, 1, 6, 1, 3, 1); add(1, 3, 7, 1, 8, 1, 3, 1);
    run("R3", 0, 0, 0);
    // R4 load distances 1, 2, 3
    add(2, 4, 1, 1); add(0, 5, 4, 1);
    run("R4", 2, 0, 0);
    add(2, 4, 1, 1); add(0, 9); add(0, 5, 4, 1);
    run("R4", 1, 0, 0);
    add(2, 4, 1, 1); add(0, 9); add(0, 10); add(0, 5, 0, 0, 4, 1);
    run("R4", 0, 0, 0);
    // R5 load into accumulate
    add(2, 7); add(1, 8, 1, 1, 2, 1, 7, 1);
    run("R5", 1, 0, 0);
    add(2, 7); add(0, 9); add(1, 8, 1, 1, 2, 1, 7, 1);
    run("R5", 0, 0, 0);
    // R6 store carries a destination tag that must not match
    add(3, 1, 2, 1, 3, 1); add(0, 4, 1, 1); add(3, 6); add(0, 2, 0, 0, 6, 1);
    run("R6", 0, 0, 0);
    // R7 store waits on buffer, others ignore it
    add(3, 0, 1, 1, 2, 1); add(0, 3);
    run("R7", 2, 2, 0);
    add(0, 1); add(1, 2); add(2, 3);
    run("R7", 0, 50, 0);
    // R8 inactive sources, acc tag on non-MAC
    add(2, 8); add(0, 9, 8, 0, 8, 0); add(0, 10, 0, 0, 0, 0, 8, 1);
    run("R8", 0, 0, 0);
    add(2, 8); add(2, 11, 0, 0, 0, 0, 8, 1);
    run("R8", 0, 0, 0);
    // R9 newer writer shadows load
    add(2, 10); add(0, 10); add(0, 12, 10, 1);
    run("R9", 0, 0, 0);
    // R11 MAC two back
    add(1, 11, 1, 1, 2, 1); add(0, 13); add(1, 14, 11, 1, 11, 1);
    run("R11", 0, 0, 0);

    // mixed random programs
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 150; k++)
        add($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7),
            1'($urandom_range(0, 1)), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            $urandom_range(0, 7), 1'($urandom_range(0, 1)));
      run("R2/R4/R5/R7/R9 random", -1, 0, 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule